// File: doc/BRIEF.md
# Bidirectional Shared Data FIFO

This block is the data buffer of a card data path. A single 32-bit by 16-word store serves both directions. In the transmit direction the bus side fills it and the card-side serializer drains it. In the receive direction the card-side deserializer fills it and the bus side drains it. Two direction-select levels come from the card clock domain. They pass through two-flop synchronizers and a direction register, and only then choose transmit, receive or off. Each change of direction empties the store.

Every data port uses valid/ready. The bus write port (transmit only) and the bus read port (receive only) follow normal back-pressure rules: a word moves only on a cycle where valid and ready are both high. The card side cannot stall. If the card raises its request (`card_out_ready`) while the store is empty, that is an underrun. If it offers a word (`card_in_valid`) while the store is full, that is an overrun and the word is lost. Both error bits are sticky until `err_clear` is pulsed.

Each direction has its own set of status flags. A set is driven only while its direction is active, and reads as all zero otherwise.

Top module: `shared_data_fifo`

## Requirements
- R1: In transmit mode, words accepted on the bus write port leave on the card output port in acceptance order. The store holds up to 16 words of 32 bits.
- R2: In receive mode, words accepted on the card input port leave on the bus read port in acceptance order.
- R3: The direction is taken from the synchronized inputs three clock edges after an input change. Transmit is selected when the transmit level is high, receive when the receive level is high, and off otherwise. While off, all readies and valids are low. Bus writes are refused in receive mode, and bus reads are refused in transmit mode.
- R4: On the cycle the registered direction changes, every ready and valid is held low. After that edge the store is empty.
- R5: In transmit mode the flags follow the occupancy n: `tx_full` is n==16, `tx_empty` is n==0, `tx_half_empty` is n<=8, and `tx_avail` is n>0.
- R6: In receive mode the flags follow the occupancy n: `rx_full` is n==16, `rx_empty` is n==0, `rx_half_full` is n>=8, and `rx_avail` is n>0.
- R7: The flags of the direction that is not active, including its error output, read 0.
- R8: In transmit mode, `card_out_ready` high while the store is empty sets a sticky underrun bit. The bit is shown on `tx_underrun` from the next edge on. `err_clear` clears it at the next edge, and the clear wins over a set in the same cycle.
- R9: In receive mode, `card_in_valid` high while the store is full sets a sticky overrun bit and the word is dropped. The bit is shown on `rx_overrun` and is cleared like R8.
- R10: A full store deasserts the ready on the filling side, and an empty store deasserts the valid on the draining side. No word is lost or duplicated.
- R11: A push and a pop in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode_async | input | 1 | Transmit-select level from the card clock domain |
| rx_mode_async | input | 1 | Receive-select level from the card clock domain |
| err_clear | input | 1 | Clears both sticky error bits |
| bus_wr_valid | input | 1 | Bus offers a word for transmit |
| bus_wr_ready | output | 1 | Store accepts a bus word |
| bus_wr_data | input | 32 | Bus write word |
| bus_rd_valid | output | 1 | Received word available to the bus |
| bus_rd_ready | input | 1 | Bus takes the received word |
| bus_rd_data | output | 32 | Head word toward the bus |
| card_out_valid | output | 1 | Transmit word available to the serializer |
| card_out_ready | input | 1 | Serializer requests a word |
| card_out_data | output | 32 | Head word toward the serializer |
| card_in_valid | input | 1 | Deserializer delivers a word |
| card_in_ready | output | 1 | Store has room for a card word |
| card_in_data | input | 32 | Deserialized word |
| tx_full | output | 1 | Transmit: store full |
| tx_empty | output | 1 | Transmit: store empty |
| tx_half_empty | output | 1 | Transmit: at most half occupied |
| tx_avail | output | 1 | Transmit: data present |
| tx_underrun | output | 1 | Transmit: sticky underrun |
| rx_full | output | 1 | Receive: store full |
| rx_empty | output | 1 | Receive: store empty |
| rx_half_full | output | 1 | Receive: at least half occupied |
| rx_avail | output | 1 | Receive: data present |
| rx_overrun | output | 1 | Receive: sticky overrun |

## Verification
The hardest state to reach is a direction switch while the store still holds words and the card side is active in the same cycle. The switch only lands three edges after the asynchronous level moves, so the pushes and pops near that edge have to be lined up with the synchronizer delay. The stimulus leaves words in the store and keeps random traffic running across each switch. The bench models the synchronizer pipeline cycle by cycle, so the flush edge, the held handshakes and the error bits set on that same edge are all compared exactly. Error-bit collisions between `err_clear` and a new underrun or overrun come from random clear pulses during long runs of full and empty stress.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [1:0] {
    DIR_OFF = 2'd0,
    DIR_TX  = 2'd1,
    DIR_RX  = 2'd2
  } dir_e;
endpackage

// File: rtl/sdf_dir_sync.sv
// Brings the two direction levels into the bus clock domain and registers the
// decoded direction; dir_chg marks the edge at which that register moves.
module sdf_dir_sync
  import sdf_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_async,
  input  logic rx_async,
  output dir_e dir,
  output logic dir_chg
);
  localparam int NBITS = 2;

  logic [NBITS-1:0] raw;
  logic [NBITS-1:0] synced;
  dir_e             dir_next;

  assign raw = {rx_async, tx_async};

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw[b]};
    end
    assign synced[b] = chain[STAGES-1];
  end

  always_comb begin
    if (synced[0])      dir_next = DIR_TX;
    else if (synced[1]) dir_next = DIR_RX;
    else                dir_next = DIR_OFF;
  end

  assign dir_chg = (dir_next != dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir <= DIR_OFF;
    else        dir <= dir_next;
  end

  // R3: the registered direction only ever holds a legal code
  assert_dir_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dir != 2'd3);
endmodule

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == FULL_N);
  assign empty = (count == '0);

  // R10: the control never pushes into a full store or pops an empty one
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && push) && !(empty && pop));
  // R4: a flush leaves the store empty
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R11: simultaneous push and pop keep the occupancy
  assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> $stable(count));
endmodule

// File: rtl/sdf_flags.sv
module sdf_flags
  import sdf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  dir_e dir,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic full,
  input  logic empty,
  input  logic card_out_ready,
  input  logic card_in_valid,
  input  logic err_clear,
  output logic tx_full,
  output logic tx_empty,
  output logic tx_half_empty,
  output logic tx_avail,
  output logic tx_underrun,
  output logic rx_full,
  output logic rx_empty,
  output logic rx_half_full,
  output logic rx_avail,
  output logic rx_overrun
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  logic is_tx, is_rx;
  logic under_q, over_q;

  assign is_tx = (dir == DIR_TX);
  assign is_rx = (dir == DIR_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      under_q <= 1'b0;
      over_q  <= 1'b0;
    end else if (err_clear) begin
      under_q <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      if (is_tx && card_out_ready && empty) under_q <= 1'b1;
      if (is_rx && card_in_valid && full)   over_q  <= 1'b1;
    end
  end

  assign tx_full       = is_tx && full;
  assign tx_empty      = is_tx && empty;
  assign tx_half_empty = is_tx && (count <= HALF);
  assign tx_avail      = is_tx && !empty;
  assign tx_underrun   = is_tx && under_q;
  assign rx_full       = is_rx && full;
  assign rx_empty      = is_rx && empty;
  assign rx_half_full  = is_rx && (count >= HALF);
  assign rx_avail      = is_rx && !empty;
  assign rx_overrun    = is_rx && over_q;

  // R8: underrun holds until a clear
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (under_q && !err_clear) |=> under_q);
  // R9: overrun holds until a clear
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (over_q && !err_clear) |=> over_q);
  // R7: never flags from both directions at once
  assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|{tx_full, tx_empty, tx_avail, tx_underrun},
              |{rx_full, rx_empty, rx_avail, rx_overrun}}));
endmodule

// File: rtl/shared_data_fifo.sv
module shared_data_fifo
  import sdf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode_async,
  input  logic              rx_mode_async,
  input  logic              err_clear,
  input  logic              bus_wr_valid,
  output logic              bus_wr_ready,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic              bus_rd_valid,
  input  logic              bus_rd_ready,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              card_out_valid,
  input  logic              card_out_ready,
  output logic [DATA_W-1:0] card_out_data,
  input  logic              card_in_valid,
  output logic              card_in_ready,
  input  logic [DATA_W-1:0] card_in_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_half_empty,
  output logic              tx_avail,
  output logic              tx_underrun,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_half_full,
  output logic              rx_avail,
  output logic              rx_overrun
);
  localparam int CNT_W = $clog2(DEPTH+1);

  dir_e              dir;
  logic              dir_chg;
  logic              is_tx, is_rx;
  logic              push, pop;
  logic [DATA_W-1:0] wdata, head;
  logic [CNT_W-1:0]  count;
  logic              full, empty;

  sdf_dir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .tx_async(tx_mode_async), .rx_async(rx_mode_async),
    .dir(dir), .dir_chg(dir_chg)
  );

  assign is_tx = (dir == DIR_TX) && !dir_chg;
  assign is_rx = (dir == DIR_RX) && !dir_chg;

  assign bus_wr_ready   = is_tx && !full;
  assign card_in_ready  = is_rx && !full;
  assign card_out_valid = is_tx && !empty;
  assign bus_rd_valid   = is_rx && !empty;

  assign push  = (bus_wr_valid && bus_wr_ready) || (card_in_valid && card_in_ready);
  assign pop   = (card_out_valid && card_out_ready) || (bus_rd_valid && bus_rd_ready);
  assign wdata = is_tx ? bus_wr_data : card_in_data;

  sdf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(dir_chg),
    .push(push), .pop(pop), .wdata(wdata),
    .rdata(head), .count(count), .full(full), .empty(empty)
  );

  assign card_out_data = head;
  assign bus_rd_data   = head;

  sdf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .dir(dir), .count(count),
    .full(full), .empty(empty),
    .card_out_ready(card_out_ready), .card_in_valid(card_in_valid),
    .err_clear(err_clear),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_half_empty(tx_half_empty),
    .tx_avail(tx_avail), .tx_underrun(tx_underrun),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_half_full(rx_half_full),
    .rx_avail(rx_avail), .rx_overrun(rx_overrun)
  );

  // R3: the bus ports and card ports of opposite directions are never live together
  assert_one_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_wr_ready || card_out_valid) && (card_in_ready || bus_rd_valid)));
  // R4: a direction switch holds all handshakes low
  assert_switch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg |-> !(bus_wr_ready || card_in_ready || card_out_valid || bus_rd_valid));
endmodule

// File: tb/shared_data_fifo_test.sv
module shared_data_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode_async = 0, rx_mode_async = 0, err_clear = 0;
  logic bus_wr_valid = 0, bus_rd_ready = 0, card_out_ready = 0, card_in_valid = 0;
  logic [DW-1:0] bus_wr_data = '0, card_in_data = '0;
  logic bus_wr_ready, bus_rd_valid, card_out_valid, card_in_ready;
  logic [DW-1:0] bus_rd_data, card_out_data;
  logic tx_full, tx_empty, tx_half_empty, tx_avail, tx_underrun;
  logic rx_full, rx_empty, rx_half_full, rx_avail, rx_overrun;

  shared_data_fifo uut (
    .clk(clk), .rst_n(rst_n),
    .tx_mode_async(tx_mode_async), .rx_mode_async(rx_mode_async),
    .err_clear(err_clear),
    .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready), .bus_wr_data(bus_wr_data),
    .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready), .bus_rd_data(bus_rd_data),
    .card_out_valid(card_out_valid), .card_out_ready(card_out_ready),
    .card_out_data(card_out_data),
    .card_in_valid(card_in_valid), .card_in_ready(card_in_ready), .card_in_data(card_in_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_half_empty(tx_half_empty),
    .tx_avail(tx_avail), .tx_underrun(tx_underrun),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_half_full(rx_half_full),
    .rx_avail(rx_avail), .rx_overrun(rx_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference model
  bit s1t, s1r, s2t, s2r;
  int mmode;            // 0 off, 1 transmit, 2 receive
  logic [DW-1:0] q[$];
  bit und, ovr;

  function automatic int decode(bit t, bit r);
    return t ? 1 : (r ? 2 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s1t = 0; s1r = 0; s2t = 0; s2r = 0; mmode = 0; q.delete(); und = 0; ovr = 0;
    end else begin
      int nm;
      bit chg, do_push, do_pop;
      logic [DW-1:0] din;
      nm = decode(s2t, s2r);
      chg = (nm != mmode);
      do_push = 0; do_pop = 0; din = '0;
      if (mmode == 1) begin
        if (card_out_ready && q.size() == 0) und = 1;
        do_push = bus_wr_valid && q.size() < DEPTH;
        din = bus_wr_data;
        do_pop = card_out_ready && q.size() > 0;
      end else if (mmode == 2) begin
        if (card_in_valid && q.size() == DEPTH) ovr = 1;
        do_push = card_in_valid && q.size() < DEPTH;
        din = card_in_data;
        do_pop = bus_rd_ready && q.size() > 0;
      end
      if (err_clear) begin und = 0; ovr = 0; end
      if (chg) begin
        q.delete();
        mmode = nm;
      end else begin
        if (do_pop) void'(q.pop_front());
        if (do_push) q.push_back(din);
      end
      s2t = s1t; s2r = s1r;
      s1t = tx_mode_async; s1r = rx_mode_async;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit chg, txa, rxa;
      int sz;
      sz = q.size();
      chg = (decode(s2t, s2r) != mmode);
      txa = (mmode == 1);
      rxa = (mmode == 2);
      chk("R3 R10 handshake",
          {60'd0, bus_wr_ready, card_in_ready, card_out_valid, bus_rd_valid},
          {60'd0, txa && !chg && sz < DEPTH, rxa && !chg && sz < DEPTH,
                  txa && !chg && sz > 0,     rxa && !chg && sz > 0});
      if (txa && !chg && sz > 0) chk("R1 R4 R11 transmit head", 64'(card_out_data), 64'(q[0]));
      if (rxa && !chg && sz > 0) chk("R2 R4 R11 receive head", 64'(bus_rd_data), 64'(q[0]));
      chk("R5 R7 transmit flags",
          {60'd0, tx_full, tx_empty, tx_half_empty, tx_avail},
          txa ? {60'd0, sz == DEPTH, sz == 0, sz <= DEPTH/2, sz > 0} : 64'd0);
      chk("R6 R7 receive flags",
          {60'd0, rx_full, rx_empty, rx_half_full, rx_avail},
          rxa ? {60'd0, sz == DEPTH, sz == 0, sz >= DEPTH/2, sz > 0} : 64'd0);
      chk("R8 underrun", 64'(tx_underrun), 64'(txa && und));
      chk("R9 overrun", 64'(rx_overrun), 64'(rxa && ovr));
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic idle_inputs();
    bus_wr_valid = 0; bus_rd_ready = 0; card_out_ready = 0; card_in_valid = 0; err_clear = 0;
  endtask

  task automatic random_traffic(input int n);
    for (int i = 0; i < n; i++) begin
      bus_wr_valid   = ($urandom % 3) != 0;
      bus_wr_data    = $urandom;
      card_in_valid  = ($urandom % 3) != 0;
      card_in_data   = $urandom;
      card_out_ready = ($urandom % 2) != 0;
      bus_rd_ready   = ($urandom % 2) != 0;
      err_clear      = ($urandom % 23) == 0;
      step(1);
    end
    idle_inputs();
  endtask

  initial begin
    step(3);
    // R3 reset: everything off and quiet
    chk("R3 reset state",
        {54'd0, bus_wr_ready, card_in_ready, card_out_valid, bus_rd_valid,
         tx_empty, tx_avail, rx_empty, rx_avail, tx_underrun, rx_overrun}, 64'd0);
    rst_n = 1;
    step(3);
    // R3 transmit select
    tx_mode_async = 1;
    step(4);
    // R1 R10: fill beyond capacity
    bus_wr_valid = 1;
    for (int i = 0; i < 20; i++) begin bus_wr_data = 32'hA000_0000 + i; step(1); end
    bus_wr_valid = 0;
    // R5 R8: drain past empty to raise underrun
    card_out_ready = 1; step(20); card_out_ready = 0;
    step(2);
    err_clear = 1; step(1); err_clear = 0;
    // R8 clear-versus-set collision
    card_out_ready = 1; err_clear = 1; step(1); err_clear = 0; step(2); card_out_ready = 0;
    // R11 concurrent traffic
    random_traffic(300);
    // R4: leave words, then switch straight to receive
    bus_wr_valid = 1;
    for (int i = 0; i < 5; i++) begin bus_wr_data = 32'hB000_0000 + i; step(1); end
    bus_wr_valid = 0;
    tx_mode_async = 0; rx_mode_async = 1;
    card_in_valid = 1; card_out_ready = 1;
    for (int i = 0; i < 6; i++) begin card_in_data = 32'hC000_0000 + i; step(1); end
    // R2 R9: overfill, while bus writes are offered and must be refused (R3)
    bus_wr_valid = 1; card_out_ready = 0;
    for (int i = 0; i < 20; i++) begin card_in_data = 32'hD000_0000 + i; step(1); end
    card_in_valid = 0; bus_wr_valid = 0;
    // R6: drain
    bus_rd_ready = 1; step(20); bus_rd_ready = 0;
    random_traffic(300);
    // R4: receive to transmit with traffic in flight
    rx_mode_async = 0; tx_mode_async = 1;
    random_traffic(300);
    // R3 R7: off, stimulus has no effect
    tx_mode_async = 0;
    random_traffic(40);
    // round trip again
    rx_mode_async = 1;
    random_traffic(200);
    rx_mode_async = 0;
    step(6);
    done = 1;
    summary();
  end
endmodule